// File: doc/BRIEF.md
# Hold Wakeup Controller

This block decides when a small microcontroller may sit in its low-power hold state and records why it left it. Five event sources can wake the core: overflow pulses from two prescaler dividers, underflow pulses from two down-counting timers, and a level change on any of four input port pins. Software arms each source through a write-only wakeup enable register. The port pins are also armed one by one through a separate write-only pin enable register, so a pin change counts only when its own pin bit is set. The same pin-qualified change drives a port interrupt request output.

When an armed source fires, the matching bit of an 8-bit cause register is set. Software reads this register as two nibbles. A non-zero cause register forces the block out of hold and keeps it out, so hold requests are refused. Software cannot write the cause register. It clears a cause bit indirectly, by writing 0 to the matching bit of the wakeup enable register or of the event enable write port. Both ports use the same bit layout as the cause register.

Top module: `hold_wake_ctrl`

## Requirements
- R1: After reset the wakeup enable bits, pin enable bits and all cause bits are 0, `in_hold` is 0 and `port_irq` is 0.
- R2: Cause and enable bit positions are: bit 0 divider-0 overflow, bit 1 timer-0 underflow, bit 2 port change, bit 4 divider-1 overflow, bit 7 timer-1 underflow. A cause bit becomes 1 on the clock edge that samples its source pulse while the matching wakeup enable bit is 1.
- R3: A pulse from a source whose wakeup enable bit is 0 leaves the cause register unchanged. Cause bits 3, 5 and 6 always read 0, even after 1s are written to those enable positions.
- R4: Pins pass through a two-flop synchronizer. A change on pin n, rising or falling, raises `port_irq` two cycles after the pin moves, but only if pin enable bit n is 1. The port cause bit (bit 2) is then set one cycle later, provided wakeup enable bit 2 is 1. Changes on pins whose pin enable bit is 0 have no effect.
- R5: A `hold_req` pulse while all cause bits are 0 makes `in_hold` 1 from the next cycle on.
- R6: While any cause bit is 1, `hold_req` is ignored and `in_hold` stays 0.
- R7: `in_hold` returns to 0 in the cycle after any cause bit becomes 1.
- R8: Writing the wakeup enable register with bit n = 0 clears cause bit n on that clock edge. That source is then disarmed.
- R9: Writing the event enable port with bit n = 0 clears cause bit n on that clock edge. Bits written as 1 leave their cause bits unchanged.
- R10: If a clear and a set hit the same cause bit on the same edge, the set wins and the bit reads 1.
- R11: `cause_lo` carries cause bits 3..0 and `cause_hi` carries cause bits 7..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wake_en_we | input | 1 | Write strobe for the wakeup enable register |
| wake_en_wdata | input | 8 | Wakeup enable write value |
| pin_en_we | input | 1 | Write strobe for the pin enable register |
| pin_en_wdata | input | 4 | Pin enable write value |
| evt_en_we | input | 1 | Write strobe for the event enable port |
| evt_en_wdata | input | 8 | Event enable write value; 0 bits clear causes |
| div0_ovf | input | 1 | Divider-0 overflow pulse |
| tmr0_unf | input | 1 | Timer-0 underflow pulse |
| div1_ovf | input | 1 | Divider-1 overflow pulse |
| tmr1_unf | input | 1 | Timer-1 underflow pulse |
| port_pins | input | 4 | Asynchronous port pin levels |
| hold_req | input | 1 | Request to enter hold |
| cause_lo | output | 4 | Cause bits 3..0 |
| cause_hi | output | 4 | Cause bits 7..4 |
| port_irq | output | 1 | Pin-qualified port change request |
| in_hold | output | 1 | Hold status |

## Verification
The hardest case to reach is a source pulse that arrives on the same edge as a write that would clear its cause bit. The set must win, and the stimulus lines up a timer pulse with an all-zero event enable write in one cycle. A second hard case is a pin change that travels through the synchronizer while the block is in hold. The bench arms one pin, toggles it and toggles a disarmed pin, then checks `port_irq` at cycle two, the cause bit at cycle three and the hold exit at cycle four.

// File: rtl/hwk_pkg.sv
package hwk_pkg;
  localparam int NSRC = 8;
  localparam int NPIN = 4;

  localparam int IDX_DIV0 = 0;
  localparam int IDX_TMR0 = 1;
  localparam int IDX_PORT = 2;
  localparam int IDX_DIV1 = 4;
  localparam int IDX_TMR1 = 7;

  typedef logic [NSRC-1:0] src_vec_t;

  // positions that carry a real source; the rest are reserved
  localparam src_vec_t IMPL_MASK = src_vec_t'((1 << IDX_DIV0) | (1 << IDX_TMR0) |
                                              (1 << IDX_PORT) | (1 << IDX_DIV1) |
                                              (1 << IDX_TMR1));

  function automatic src_vec_t pack_sources(input logic div0, input logic tmr0,
                                            input logic port, input logic div1,
                                            input logic tmr1);
    src_vec_t v;
    v = '0;
    v[IDX_DIV0] = div0;
    v[IDX_TMR0] = tmr0;
    v[IDX_PORT] = port;
    v[IDX_DIV1] = div1;
    v[IDX_TMR1] = tmr1;
    return v;
  endfunction

  // bits written as 0 by an active strobe request a clear
  function automatic src_vec_t zero_write_mask(input logic we, input src_vec_t wdata);
    return we ? ~wdata : '0;
  endfunction

  // set has priority over clear on the same bit
  function automatic src_vec_t next_cause(input src_vec_t cur, input src_vec_t set_v,
                                          input src_vec_t clr_v);
    return ((cur & ~clr_v) | set_v) & IMPL_MASK;
  endfunction
endpackage

// File: rtl/hwk_pin_watch.sv
module hwk_pin_watch #(
  parameter int NPIN        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic [NPIN-1:0] pin_en,
  output logic            pin_evt
);
  logic [NPIN-1:0] stg [SYNC_STAGES];
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] synced;
  logic [NPIN-1:0] diff_raw;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= pins;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign synced = stg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= synced;
  end

  assign diff_raw = synced ^ prev_q;
  assign pin_evt  = |(diff_raw & pin_en);

  // R4
  pin_evt_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt |-> (pin_en != '0));

  // R4
  prev_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_raw != '0) |=> (prev_q == $past(synced)));
endmodule

// File: rtl/hwk_cause_reg.sv
module hwk_cause_reg
  import hwk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  src_vec_t clr_vec,
  output src_vec_t cause_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= next_cause(cause_q, set_vec, clr_vec);
  end

  // R2 R10
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  // R8 R9
  cause_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((cause_q & $past(clr_vec & ~set_vec)) == '0));

  // R3
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec == '0) && (clr_vec == '0)) |=> $stable(cause_q));
endmodule

// File: rtl/hwk_hold_ctrl.sv
module hwk_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic wake_any,
  output logic in_hold
);
  logic hold_accept;

  assign hold_accept = hold_req && !wake_any && !in_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_hold <= 1'b0;
    else if (wake_any) in_hold <= 1'b0;
    else if (hold_accept) in_hold <= 1'b1;
  end

  // R5
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && !wake_any) |=> in_hold);

  // R6
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_any && !in_hold) |=> !in_hold);

  // R7
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && wake_any) |=> !in_hold);
endmodule

// File: rtl/hold_wake_ctrl.sv
module hold_wake_ctrl
  import hwk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_en_we,
  input  logic [7:0] wake_en_wdata,
  input  logic       pin_en_we,
  input  logic [3:0] pin_en_wdata,
  input  logic       evt_en_we,
  input  logic [7:0] evt_en_wdata,
  input  logic       div0_ovf,
  input  logic       tmr0_unf,
  input  logic       div1_ovf,
  input  logic       tmr1_unf,
  input  logic [3:0] port_pins,
  input  logic       hold_req,
  output logic [3:0] cause_lo,
  output logic [3:0] cause_hi,
  output logic       port_irq,
  output logic       in_hold
);
  localparam int HALF = NSRC / 2;

  src_vec_t        wake_en_q;
  logic [NPIN-1:0] pin_en_q;
  src_vec_t        src_pulse;
  src_vec_t        set_vec;
  src_vec_t        clr_vec;
  src_vec_t        cause_q;
  logic            port_evt;
  logic            wake_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_en_q <= '0;
      pin_en_q  <= '0;
    end else begin
      if (wake_en_we) wake_en_q <= wake_en_wdata & IMPL_MASK;
      if (pin_en_we)  pin_en_q  <= pin_en_wdata;
    end
  end

  hwk_pin_watch #(.NPIN(NPIN), .SYNC_STAGES(2)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (port_pins),
    .pin_en (pin_en_q),
    .pin_evt(port_evt)
  );

  assign src_pulse = pack_sources(div0_ovf, tmr0_unf, port_evt, div1_ovf, tmr1_unf);
  assign set_vec   = src_pulse & wake_en_q;
  assign clr_vec   = zero_write_mask(wake_en_we, wake_en_wdata) |
                     zero_write_mask(evt_en_we, evt_en_wdata);

  hwk_cause_reg u_cause (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .cause_q(cause_q)
  );

  assign wake_any = |cause_q;

  hwk_hold_ctrl u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_req(hold_req),
    .wake_any(wake_any),
    .in_hold (in_hold)
  );

  assign cause_lo = cause_q[HALF-1:0];
  assign cause_hi = cause_q[NSRC-1:HALF];
  assign port_irq = port_evt;

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({cause_hi, cause_lo} & ~IMPL_MASK) == '0);

  // R3
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_en_q[IDX_TMR1] && !evt_en_we && !wake_en_we) |=> ($past(cause_q[IDX_TMR1]) == cause_q[IDX_TMR1]));
endmodule

// File: tb/tb_hold_wake_ctrl.sv
module tb_hold_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wake_en_we = 0;
  logic [7:0] wake_en_wdata = 0;
  logic       pin_en_we = 0;
  logic [3:0] pin_en_wdata = 0;
  logic       evt_en_we = 0;
  logic [7:0] evt_en_wdata = 0;
  logic       div0_ovf = 0, tmr0_unf = 0, div1_ovf = 0, tmr1_unf = 0;
  logic [3:0] port_pins = 0;
  logic       hold_req = 0;
  logic [3:0] cause_lo, cause_hi;
  logic       port_irq, in_hold;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [7:0] cause;
    logic       hold;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  hold_wake_ctrl dut (.*);

  // monitor: compare queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if ({cause_hi, cause_lo} !== e.cause || in_hold !== e.hold || port_irq !== e.irq) begin
          n_bad++;
          $display("FAIL %s: cause=%h hold=%b irq=%b expected cause=%h hold=%b irq=%b",
                   e.tag, {cause_hi, cause_lo}, in_hold, port_irq, e.cause, e.hold, e.irq);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic [7:0] c, input logic h, input logic i, input string tag);
    exp_t e;
    e.cause = c; e.hold = h; e.irq = i; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    wake_en_we = 0; pin_en_we = 0; evt_en_we = 0;
    div0_ovf = 0; tmr0_unf = 0; div1_ovf = 0; tmr1_unf = 0; hold_req = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_out(8'h00, 0, 0, "R1 reset state");
    tick();

    // R5 enter hold
    hold_req = 1; tick(); idle();
    expect_out(8'h00, 1, 0, "R5 hold entry");

    // R3 disarmed source ignored
    div0_ovf = 1; tick(); idle();
    expect_out(8'h00, 1, 0, "R3 disarmed divider ignored");

    // arm everything, reserved bits too
    wake_en_we = 1; wake_en_wdata = 8'hFF; tick(); idle();
    expect_out(8'h00, 1, 0, "R3 enable write alone sets nothing");

    // R2 divider-0 wakes; R7 exit one cycle later
    div0_ovf = 1; tick(); idle();
    expect_out(8'h01, 1, 0, "R2 divider0 cause bit0");
    tick();
    expect_out(8'h01, 0, 0, "R7 hold drops after cause");

    // R6 hold request refused
    hold_req = 1; tick(); idle();
    expect_out(8'h01, 0, 0, "R6 hold blocked");
    tick();
    expect_out(8'h01, 0, 0, "R6 still out of hold");

    // R9 clear via event enable port
    evt_en_we = 1; evt_en_wdata = 8'hFE; tick(); idle();
    expect_out(8'h00, 0, 0, "R9 event enable clear");

    // R2 R11 all timer/divider sources at once
    div0_ovf = 1; tmr0_unf = 1; div1_ovf = 1; tmr1_unf = 1; tick(); idle();
    expect_out(8'h93, 0, 0, "R2 R11 nibble split, reserved zero");

    // R9 ones leave bits alone
    evt_en_we = 1; evt_en_wdata = 8'hFF; tick(); idle();
    expect_out(8'h93, 0, 0, "R9 ones keep causes");

    // R8 clear via wake enable bit7
    wake_en_we = 1; wake_en_wdata = 8'h7F; tick(); idle();
    expect_out(8'h13, 0, 0, "R8 wake enable clear bit7");
    tmr1_unf = 1; tick(); idle();
    expect_out(8'h13, 0, 0, "R8 R3 disarmed timer1 ignored");
    evt_en_we = 1; evt_en_wdata = 8'h00; tick(); idle();
    expect_out(8'h00, 0, 0, "R9 clear all");
    wake_en_we = 1; wake_en_wdata = 8'hFF; tick(); idle();

    // R10 set beats clear on same edge
    tmr0_unf = 1; evt_en_we = 1; evt_en_wdata = 8'h00; tick(); idle();
    expect_out(8'h02, 0, 0, "R10 set wins over clear");
    evt_en_we = 1; evt_en_wdata = 8'hFD; tick(); idle();
    expect_out(8'h00, 0, 0, "R9 clear bit1");

    // R4 pin changes without pin enable
    port_pins = 4'b0001;
    repeat (4) tick();
    expect_out(8'h00, 0, 0, "R4 disabled pin ignored");

    // arm pin0 only, enter hold
    pin_en_we = 1; pin_en_wdata = 4'b0001; hold_req = 1; tick(); idle();
    expect_out(8'h00, 1, 0, "R5 hold re-entry");

    port_pins = 4'b0011; // pin1 rises, disarmed
    repeat (4) tick();
    expect_out(8'h00, 1, 0, "R4 disarmed pin1 ignored");

    port_pins = 4'b0010; // pin0 falls, armed
    tick(); tick();
    expect_out(8'h00, 1, 1, "R4 port_irq after sync");
    tick();
    expect_out(8'h04, 1, 0, "R4 port cause bit2");
    tick();
    expect_out(8'h04, 0, 0, "R7 port wake exits hold");

    evt_en_we = 1; evt_en_wdata = 8'hFB; tick(); idle();
    expect_out(8'h00, 0, 0, "R9 clear port cause");

    tick();
    tick();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule